// File: doc/BRIEF.md
# Output Voltage Ramp Controller

This block moves a regulator's digital voltage setpoint from its present value to a newly requested target at a chosen slew rate. The setpoint and target are held as millivolt integers. The legal setpoints lie on a grid made of three bands, and each band has its own spacing. Below 730 mV the spacing is 10 mV, from 730 mV up to 1395 mV it is 5 mV, and from 1400 mV to 3360 mV it is 20 mV. The lowest legal value is 700 mV.

A free-running one-microsecond tick drives a fixed-point accumulator kept in hundredths of a millivolt. On each tick the accumulator gains an amount set by a three-bit slew code. Whenever the accumulator holds at least one grid step of the present band, the setpoint moves by exactly one grid step toward the target. The block owner supplies the tick and the target load strobe. The tick must be at least two clocks apart.

Top module: `vr_ramp_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `setpoint_mv` is 1000, `busy` is 0, `done` is 0 and `tgt_err` is 0.
- R2: A target is legal only if it is inside 700..3360 and on the grid. The grid is 700, 710 and 720, then multiples of 5 from 730 to 1395, then 1400 plus multiples of 20 up to 3360. An illegal load sets `tgt_err`, which stays set until reset. It changes neither the setpoint nor a ramp in progress, and that ramp continues toward its old target.
- R3: Every setpoint change moves to the adjacent grid point. A move going up from below 730 is 10 mV, and going down from 730 or below is 10 mV. A move going up from 1400 or above is 20 mV, and going down from above 1400 is 20 mV. Every other move is 5 mV.
- R4: Each `us_tick` sampled while busy and enabled adds a rate, in hundredths of a mV, to the accumulator. The rates by code are 010=1000, 011=750, 100=380, 101=190, 110=94 and 111=47. A step is taken in a cycle where the registered accumulator is at least 100 times the step size, and that amount is then subtracted from the accumulator.
- R5: Slew codes 000 and 001 use the same rate as code 010.
- R6: The last step lands exactly on the target. In the cycle after that step, `done` is 1 for one clock and `busy` is 0. While idle, the setpoint does not change.
- R7: When a legal target is loaded during a ramp, the ramp restarts from the present setpoint toward the new target, with the accumulator cleared.
- R8: A legal load equal to the present setpoint gives `done`=1 for one clock in the following cycle, and `busy` stays 0.
- R9: While `enable` is 0, the accumulator and setpoint are frozen. Loads are still accepted.
- R10: A legal load in the same cycle as a due step wins: that step is discarded and the ramp restarts from the unstepped setpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Ramp run enable |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| tgt_load | input | 1 | Strobe to load `tgt_mv` |
| tgt_mv | input | 12 | Requested target in mV |
| slew_code | input | 3 | Slew-rate select |
| setpoint_mv | output | 12 | Present setpoint in mV |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | One-cycle pulse when the target is reached |
| tgt_err | output | 1 | Sticky rejected-target flag |

## Verification
The collision of interest is a target load arriving in the same clock as a due grid step. A lesser case is a tick and a step draining the accumulator together. Both are provoked by issuing a burst of loads at irregular gaps of zero to four clocks during a fast 5 mV-band ramp, so that some loads meet a pending step. A behavioural reference model in the bench predicts the setpoint, busy, done and error flag every clock. Any cycle where the step was not dropped in favour of the restart shows up as a mismatch.

// File: rtl/vr_pkg.sv
package vr_pkg;
    localparam int MV_W  = 12;
    localparam int ACC_W = 16;
    localparam int CENTI = 100;

    localparam logic [MV_W-1:0] LO_MV  = MV_W'(700);
    localparam logic [MV_W-1:0] MID_MV = MV_W'(730);
    localparam logic [MV_W-1:0] HI_MV  = MV_W'(1400);
    localparam logic [MV_W-1:0] TOP_MV = MV_W'(3360);

    localparam int STEP_LO_I  = 10;
    localparam int STEP_MID_I = 5;
    localparam int STEP_HI_I  = 20;

    localparam logic [MV_W-1:0]  STEP_LO  = MV_W'(STEP_LO_I);
    localparam logic [MV_W-1:0]  STEP_MID = MV_W'(STEP_MID_I);
    localparam logic [MV_W-1:0]  STEP_HI  = MV_W'(STEP_HI_I);
    localparam logic [ACC_W-1:0] STEP_LO_C  = ACC_W'(STEP_LO_I * CENTI);
    localparam logic [ACC_W-1:0] STEP_MID_C = ACC_W'(STEP_MID_I * CENTI);
    localparam logic [ACC_W-1:0] STEP_HI_C  = ACC_W'(STEP_HI_I * CENTI);

    typedef struct packed {
        logic [MV_W-1:0]  sp;
        logic [MV_W-1:0]  tgt;
        logic [ACC_W-1:0] acc;
        logic             busy;
        logic             done;
        logic             err;
    } vr_state_t;
endpackage

// File: rtl/vr_grid_chk.sv
module vr_grid_chk
    import vr_pkg::*;
(
    input  logic [MV_W-1:0] mv,
    output logic            legal
);
    logic [MV_W-1:0] off_lo, off_mid, off_hi;

    always_comb begin
        off_lo  = mv - LO_MV;
        off_mid = mv - MID_MV;
        off_hi  = mv - HI_MV;
        if (mv < LO_MV || mv > TOP_MV) begin
            legal = 1'b0;
        end else if (mv < MID_MV) begin
            legal = (off_lo % STEP_LO) == '0;
        end else if (mv < HI_MV) begin
            legal = (off_mid % STEP_MID) == '0;
        end else begin
            legal = (off_hi % STEP_HI) == '0;
        end
    end
endmodule

// File: rtl/vr_rate_sel.sv
module vr_rate_sel
    import vr_pkg::*;
(
    input  logic [2:0]       code,
    output logic [ACC_W-1:0] rate
);
    always_comb begin
        unique case (code)
            3'b011:  rate = ACC_W'(750);
            3'b100:  rate = ACC_W'(380);
            3'b101:  rate = ACC_W'(190);
            3'b110:  rate = ACC_W'(94);
            3'b111:  rate = ACC_W'(47);
            default: rate = ACC_W'(1000);   // 000, 001, 010
        endcase
    end
endmodule

// File: rtl/vr_step_sel.sv
module vr_step_sel
    import vr_pkg::*;
(
    input  logic [MV_W-1:0]  sp,
    input  logic             up,
    output logic [MV_W-1:0]  step_mv,
    output logic [ACC_W-1:0] step_cent
);
    logic in_lo, in_mid;

    always_comb begin
        // band of the interval being crossed, not of the start point
        in_lo  = up ? (sp <  MID_MV) : (sp <= MID_MV);
        in_mid = up ? (sp <  HI_MV)  : (sp <= HI_MV);
        if (in_lo) begin
            step_mv   = STEP_LO;
            step_cent = STEP_LO_C;
        end else if (in_mid) begin
            step_mv   = STEP_MID;
            step_cent = STEP_MID_C;
        end else begin
            step_mv   = STEP_HI;
            step_cent = STEP_HI_C;
        end
    end
endmodule

// File: rtl/vr_ramp_ctrl.sv
module vr_ramp_ctrl
    import vr_pkg::*;
#(
    parameter logic [MV_W-1:0] INIT_MV = MV_W'(1000)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            us_tick,
    input  logic            tgt_load,
    input  logic [MV_W-1:0] tgt_mv,
    input  logic [2:0]      slew_code,
    output logic [MV_W-1:0] setpoint_mv,
    output logic            busy,
    output logic            done,
    output logic            tgt_err
);
    vr_state_t state_d, state_q;

    logic             tgt_ok;
    logic [ACC_W-1:0] rate;
    logic             go_up;
    logic [MV_W-1:0]  step_mv;
    logic [ACC_W-1:0] step_cent;
    logic             accept_d;
    logic             commit_d;
    logic [ACC_W-1:0] acc_d;
    logic [MV_W-1:0]  sp_step_d;

    vr_grid_chk u_grid (.mv(tgt_mv), .legal(tgt_ok));
    vr_rate_sel u_rate (.code(slew_code), .rate(rate));
    vr_step_sel u_step (
        .sp       (state_q.sp),
        .up       (go_up),
        .step_mv  (step_mv),
        .step_cent(step_cent)
    );

    assign go_up = state_q.tgt > state_q.sp;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        accept_d     = tgt_load && tgt_ok;
        commit_d     = state_q.busy && enable && (state_q.acc >= step_cent);
        acc_d        = state_q.acc;
        sp_step_d    = go_up ? state_q.sp + step_mv : state_q.sp - step_mv;

        if (tgt_load && !tgt_ok) begin
            state_d.err = 1'b1;
        end

        if (accept_d) begin
            state_d.tgt  = tgt_mv;
            state_d.acc  = '0;
            state_d.busy = (tgt_mv != state_q.sp);
            state_d.done = (tgt_mv == state_q.sp);
        end else if (state_q.busy) begin
            if (commit_d) begin
                acc_d = acc_d - step_cent;
            end
            if (enable && us_tick) begin
                acc_d = acc_d + rate;
            end
            state_d.acc = acc_d;
            if (commit_d) begin
                state_d.sp = sp_step_d;
                if (sp_step_d == state_q.tgt) begin
                    state_d.busy = 1'b0;
                    state_d.done = 1'b1;
                    state_d.acc  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.sp   <= INIT_MV;
            state_q.tgt  <= INIT_MV;
            state_q.acc  <= '0;
            state_q.busy <= 1'b0;
            state_q.done <= 1'b0;
            state_q.err  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign setpoint_mv = state_q.sp;
    assign busy        = state_q.busy;
    assign done        = state_q.done;
    assign tgt_err     = state_q.err;

    p_bad_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_load && !tgt_ok |=> tgt_err);

    p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_err |=> tgt_err);

    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        setpoint_mv >= LO_MV && setpoint_mv <= TOP_MV);

    p_step_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(setpoint_mv) |->
            ((setpoint_mv - $past(setpoint_mv)) == STEP_MID ||
             ($past(setpoint_mv) - setpoint_mv) == STEP_MID ||
             (setpoint_mv - $past(setpoint_mv)) == STEP_LO ||
             ($past(setpoint_mv) - setpoint_mv) == STEP_LO ||
             (setpoint_mv - $past(setpoint_mv)) == STEP_HI ||
             ($past(setpoint_mv) - setpoint_mv) == STEP_HI));

    p_done_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> setpoint_mv == state_q.tgt && !busy);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(setpoint_mv));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !tgt_load |=> !done);

    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(setpoint_mv));

    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_load && tgt_ok |=> $stable(setpoint_mv));
endmodule

// File: tb/tb_vr_ramp_ctrl.sv
module tb_vr_ramp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        us_tick = 1'b0;
    logic        tgt_load = 1'b0;
    logic [11:0] tgt_mv = 12'd1000;
    logic [2:0]  slew_code = 3'b010;
    logic [11:0] setpoint_mv;
    logic        busy, done, tgt_err;

    vr_ramp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .us_tick(us_tick),
        .tgt_load(tgt_load), .tgt_mv(tgt_mv), .slew_code(slew_code),
        .setpoint_mv(setpoint_mv), .busy(busy), .done(done), .tgt_err(tgt_err)
    );

    always #5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_sp = 1000, m_tgt = 1000, m_acc = 0;
    bit m_busy = 0, m_done = 0, m_err = 0;

    function automatic bit legal(int t);
        if (t < 700 || t > 3360) return 0;
        if (t < 730) return ((t - 700) % 10) == 0;
        if (t < 1400) return (t % 5) == 0;
        return ((t - 1400) % 20) == 0;
    endfunction

    function automatic int step_of(int s, bit up);
        int lower;
        lower = up ? s : s - 1;   // band of the interval crossed
        if (lower < 730) return 10;
        if (lower < 1400) return 5;
        return 20;
    endfunction

    function automatic int rate_of(logic [2:0] c);
        case (c)
            3'd3: return 750;
            3'd4: return 380;
            3'd5: return 190;
            3'd6: return 94;
            3'd7: return 47;
            default: return 1000;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_sp = 1000; m_tgt = 1000; m_acc = 0;
            m_busy = 0; m_done = 0; m_err = 0;
        end else begin
            int  st, na;
            bit  up, due;
            m_done = 0;
            if (tgt_load && legal(int'(tgt_mv))) begin
                m_tgt  = int'(tgt_mv);
                m_acc  = 0;
                m_busy = (m_tgt != m_sp);
                m_done = (m_tgt == m_sp);
            end else begin
                if (tgt_load) m_err = 1;
                if (m_busy) begin
                    up  = m_tgt > m_sp;
                    st  = step_of(m_sp, up);
                    due = enable && (m_acc >= st * 100);
                    na  = m_acc;
                    if (due) na -= st * 100;
                    if (enable && us_tick) na += rate_of(slew_code);
                    m_acc = na;
                    if (due) begin
                        m_sp = up ? m_sp + st : m_sp - st;
                        if (m_sp == m_tgt) begin
                            m_busy = 0; m_done = 1; m_acc = 0;
                        end
                    end
                end
            end
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(setpoint_mv) == m_sp, {cur_req, " setpoint"}, int'(setpoint_mv), m_sp);
            check(busy == m_busy, {cur_req, " busy"}, int'(busy), int'(m_busy));
            check(done == m_done, {cur_req, " done"}, int'(done), int'(m_done));
            check(tgt_err == m_err, {cur_req, " err"}, int'(tgt_err), int'(m_err));
        end
    end

    // microsecond tick every 4 clocks
    int tick_cnt = 0;
    always @(negedge clk) begin
        tick_cnt = (tick_cnt == 3) ? 0 : tick_cnt + 1;
        us_tick  = (tick_cnt == 3);
    end

    task automatic load(int t);
        @(negedge clk);
        tgt_mv   = 12'(t);
        tgt_load = 1'b1;
        @(negedge clk);
        tgt_load = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
        @(negedge clk);
    endtask

    task automatic ramp_to(int t, logic [2:0] c);
        slew_code = c;
        load(t);
        wait_idle();
        check(int'(setpoint_mv) == t, "R6 lands on target", int'(setpoint_mv), t);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(int'(setpoint_mv) == 1000, "R1 reset setpoint", int'(setpoint_mv), 1000);
        check(busy == 0 && done == 0 && tgt_err == 0, "R1 reset flags",
              int'({busy, done, tgt_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(setpoint_mv) == 1000, "R1 after release", int'(setpoint_mv), 1000);

        cur_req = "R4";
        ramp_to(1200, 3'b010);
        cur_req = "R5";
        ramp_to(1100, 3'b000);
        ramp_to(1150, 3'b001);

        cur_req = "R3";
        ramp_to(700, 3'b010);
        ramp_to(1500, 3'b011);
        ramp_to(1380, 3'b010);
        ramp_to(1420, 3'b010);

        cur_req = "R4";
        ramp_to(1600, 3'b100);
        ramp_to(1560, 3'b101);
        ramp_to(1580, 3'b110);
        ramp_to(1540, 3'b111);

        cur_req = "R2";
        slew_code = 3'b010;
        load(2000);
        repeat (10) @(negedge clk);
        load(3380);
        check(tgt_err == 1, "R2 out of range sets err", int'(tgt_err), 1);
        load(690);
        load(1402);
        load(715);
        load(1397);
        wait_idle();
        check(int'(setpoint_mv) == 2000, "R2 ramp kept old target", int'(setpoint_mv), 2000);
        check(tgt_err == 1, "R2 err sticky", int'(tgt_err), 1);

        cur_req = "R7";
        load(2500);
        repeat (40) @(negedge clk);
        ramp_to(1800, 3'b010);

        cur_req = "R8";
        load(1800);
        check(done == 1 && busy == 0, "R8 equal target done", int'({done, busy}), 2);
        @(negedge clk);
        check(done == 0, "R8 done one clock", int'(done), 0);

        cur_req = "R9";
        slew_code = 3'b010;
        load(1000);
        repeat (20) @(negedge clk);
        enable = 1'b0;
        begin
            int held;
            held = int'(setpoint_mv);
            repeat (60) @(negedge clk);
            check(int'(setpoint_mv) == held, "R9 frozen while disabled", int'(setpoint_mv), held);
        end
        load(1100);
        enable = 1'b1;
        wait_idle();
        check(int'(setpoint_mv) == 1100, "R9 load accepted while disabled", int'(setpoint_mv), 1100);

        cur_req = "R10";
        slew_code = 3'b010;
        load(1300);
        for (int i = 0; i < 40; i++) begin
            repeat (i % 5) @(negedge clk);
            load((i % 2) ? 1300 : 1000);
        end
        wait_idle();

        cur_req = "R3";
        ramp_to(700, 3'b010);
        ramp_to(3360, 3'b111);
        ramp_to(700, 3'b010);

        repeat (5) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule